// File: doc/BRIEF.md
# Dual-Clock Synchronous Dual-Port RAM with Per-Port Read Latency

This block is a word-organised static memory with two fully independent ports, called left and right. Each port has its own clock and its own synchronous reset. On every rising edge of its clock, a port can read or write any location, whatever the other port is doing. Addresses, write data and control inputs are sampled on the port's own rising edge. The storage is a behavioural array that a synthesis flow can map onto block RAM.

Each port has two gating inputs, one active low and one active high. The port acts only when both are in their active state.

A static mode pin sets the read latency of each port:
- In flow-through mode, read data is visible right after the edge that samples the address.
- In pipelined mode, read data passes through one more output register and appears one edge later.

The read output changes only for a completed read while the output enable is active. At all other times it holds its last value.

The width parameter `ADDR_W` sets the depth. A value of 14 gives 16K words and 13 gives 8K. The default is a small 2K so that a default elaboration stays light. Words are 9 bits by default.

Top module: `dpram_dual_sync`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits. Address 2^ADDR_W-1 and address 0 are separate words, and an all-ones word is stored without loss.
- R2: A port is selected only when `gate_n_x` is 0 and `gate_x` is 1. With the other three combinations, the port neither writes the array nor starts a read.
- R3: In a selected cycle, `wr_n_x` = 0 writes `wdata_x` to `addr_x` at the rising edge, and `wr_n_x` = 1 reads `addr_x`.
- R4: With `pipe_x` = 0, the read data of an address sampled at edge k is on `rdata_x` after edge k and before edge k+1.
- R5: With `pipe_x` = 1, the data of a read sampled at edge k appears on `rdata_x` after edge k+1. After edge k, the output still holds its earlier value.
- R6: `drive_n_x` is sampled on each edge, and `rdata_x` is updated only when the sample taken on the edge that makes the data visible is 0. That edge is edge k in flow-through mode and edge k+1 in pipelined mode. Otherwise the output holds.
- R7: `rdata_x` holds its previous value after any edge that completes no read. This covers write cycles and deselected cycles.
- R8: In pipelined mode, a port that was deselected on edge k-1 and reads on edge k shows nothing new after edge k. Its reads at edges k and k+1 appear after edges k+1 and k+2.
- R9: When the two clocks rise together, a read on one port of the location the other port writes in that edge returns the old contents. Writes by both ports to one location in the same edge leave an undefined value.
- R10: Both ports can write different locations on the same edge. Each location is then readable from either port.
- R11: `rst_x` = 1 at a rising edge of `clk_x` clears that port's output to 0 and cancels its pending read. The memory contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l | input | 1 | Left port synchronous reset, active high |
| addr_l | input | ADDR_W | Left port address |
| wdata_l | input | DATA_W | Left port write data |
| wr_n_l | input | 1 | Left port: 0 writes, 1 reads |
| drive_n_l | input | 1 | Left port output enable, active low |
| gate_n_l | input | 1 | Left port gate, active low |
| gate_l | input | 1 | Left port gate, active high |
| pipe_l | input | 1 | Left port mode: 0 flow-through, 1 pipelined |
| rdata_l | output | DATA_W | Left port read data |
| clk_r | input | 1 | Right port clock |
| rst_r | input | 1 | Right port synchronous reset, active high |
| addr_r | input | ADDR_W | Right port address |
| wdata_r | input | DATA_W | Right port write data |
| wr_n_r | input | 1 | Right port: 0 writes, 1 reads |
| drive_n_r | input | 1 | Right port output enable, active low |
| gate_n_r | input | 1 | Right port gate, active low |
| gate_r | input | 1 | Right port gate, active high |
| pipe_r | input | 1 | Right port mode: 0 flow-through, 1 pipelined |
| rdata_r | output | DATA_W | Right port read data |

## Verification
The hardest case to reach from the ports is a read on one port landing on the same edge as a write by the other port to the same word. That case exposes how the two banks combine.

The bench runs both clocks in phase. It applies a right-port read and a left-port write to one address in a single drive window. The old word must come out of the pipelined right port two edges later, and the new word must come out on a later left read.

A second hard case is the pipelined restart after deselection. The bench reaches it by issuing two back-to-back reads straight after an idle edge, then checking the output after each of the three following edges.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Request decoded from one port's raw inputs for the current edge.
  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
  } port_req_t;

  function automatic port_req_t decode_req(input logic gate_n,
                                           input logic gate,
                                           input logic wr_n);
    port_req_t r;
    r.sel = !gate_n && gate;
    r.wr  = r.sel && !wr_n;
    r.rd  = r.sel && wr_n;
    return r;
  endfunction

endpackage

// File: rtl/dpram_port_in.sv
module dpram_port_in
  import dpram_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_n,
  input  logic      drive_n,
  input  logic      gate_n,
  input  logic      gate,
  input  logic      pipe,
  output port_req_t req,
  output logic      rd_v_q,
  output logic      oe_q,
  output logic      pipe_q
);

  always_comb req = decode_req(gate_n, gate, wr_n);

  // Control sampled on the port's own edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v_q <= 1'b0;
      oe_q   <= 1'b0;
      pipe_q <= pipe;
    end else begin
      rd_v_q <= req.rd;
      oe_q   <= !drive_n;
      pipe_q <= pipe;
    end
  end

endmodule

// File: rtl/dpram_xor_store.sv
module dpram_xor_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk_a,
  input  logic              we_a,
  input  logic              re_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wd_a,
  output logic [DATA_W-1:0] rd_a,
  input  logic              clk_b,
  input  logic              we_b,
  input  logic              re_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wd_b,
  output logic [DATA_W-1:0] rd_b
);
  localparam int DEPTH = 1 << ADDR_W;

  // Each port owns one bank; a word is the XOR of both banks.
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      bank_a[i] = '0;
      bank_b[i] = '0;
    end
  end

  always_ff @(posedge clk_a) begin
    if (re_a) rd_a <= bank_a[addr_a] ^ bank_b[addr_a];
    if (we_a) bank_a[addr_a] <= wd_a ^ bank_b[addr_a];
  end

  always_ff @(posedge clk_b) begin
    if (re_b) rd_b <= bank_a[addr_b] ^ bank_b[addr_b];
    if (we_b) bank_b[addr_b] <= wd_b ^ bank_a[addr_b];
  end

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_q,
  input  logic              rd_v_q,
  input  logic              oe_q,
  input  logic [DATA_W-1:0] fresh,
  output logic [DATA_W-1:0] rdata
);
  logic              pv;
  logic [DATA_W-1:0] pdata;
  logic [DATA_W-1:0] hold;
  logic              show;
  logic [DATA_W-1:0] src;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv    <= 1'b0;
      pdata <= '0;
      hold  <= '0;
    end else begin
      pv   <= rd_v_q;
      if (rd_v_q) pdata <= fresh;
      hold <= rdata;
    end
  end

  always_comb begin
    show  = pipe_q ? (pv & oe_q) : (rd_v_q & oe_q);
    src   = pipe_q ? pdata : fresh;
    rdata = show ? src : hold;
  end

endmodule

// File: rtl/dpram_dual_sync.sv
module dpram_dual_sync
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk_l,
  input  logic              rst_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] wdata_l,
  input  logic              wr_n_l,
  input  logic              drive_n_l,
  input  logic              gate_n_l,
  input  logic              gate_l,
  input  logic              pipe_l,
  output logic [DATA_W-1:0] rdata_l,
  input  logic              clk_r,
  input  logic              rst_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wdata_r,
  input  logic              wr_n_r,
  input  logic              drive_n_r,
  input  logic              gate_n_r,
  input  logic              gate_r,
  input  logic              pipe_r,
  output logic [DATA_W-1:0] rdata_r
);
  port_req_t         req_l, req_r;
  logic              rdv_l, rdv_r, oe_l, oe_r, pq_l, pq_r;
  logic [DATA_W-1:0] fresh_l, fresh_r;

  dpram_port_in u_in_l (
    .clk(clk_l), .rst(rst_l), .wr_n(wr_n_l), .drive_n(drive_n_l),
    .gate_n(gate_n_l), .gate(gate_l), .pipe(pipe_l),
    .req(req_l), .rd_v_q(rdv_l), .oe_q(oe_l), .pipe_q(pq_l)
  );

  dpram_port_in u_in_r (
    .clk(clk_r), .rst(rst_r), .wr_n(wr_n_r), .drive_n(drive_n_r),
    .gate_n(gate_n_r), .gate(gate_r), .pipe(pipe_r),
    .req(req_r), .rd_v_q(rdv_r), .oe_q(oe_r), .pipe_q(pq_r)
  );

  dpram_xor_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_a(clk_l), .we_a(req_l.wr), .re_a(req_l.rd), .addr_a(addr_l),
    .wd_a(wdata_l), .rd_a(fresh_l),
    .clk_b(clk_r), .we_b(req_r.wr), .re_b(req_r.rd), .addr_b(addr_r),
    .wd_b(wdata_r), .rd_b(fresh_r)
  );

  dpram_port_out #(.DATA_W(DATA_W)) u_out_l (
    .clk(clk_l), .rst(rst_l), .pipe_q(pq_l), .rd_v_q(rdv_l), .oe_q(oe_l),
    .fresh(fresh_l), .rdata(rdata_l)
  );

  dpram_port_out #(.DATA_W(DATA_W)) u_out_r (
    .clk(clk_r), .rst(rst_r), .pipe_q(pq_r), .rd_v_q(rdv_r), .oe_q(oe_r),
    .fresh(fresh_r), .rdata(rdata_r)
  );

endmodule

// File: rtl/dpram_dual_sync_chk.sv
module dpram_dual_sync_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input logic              clk_l,
  input logic              rst_l,
  input logic [ADDR_W-1:0] addr_l,
  input logic [DATA_W-1:0] wdata_l,
  input logic              wr_n_l,
  input logic              drive_n_l,
  input logic              gate_n_l,
  input logic              gate_l,
  input logic              pipe_l,
  input logic [DATA_W-1:0] rdata_l,
  input logic              clk_r,
  input logic              rst_r,
  input logic [ADDR_W-1:0] addr_r,
  input logic [DATA_W-1:0] wdata_r,
  input logic              wr_n_r,
  input logic              drive_n_r,
  input logic              gate_n_r,
  input logic              gate_r,
  input logic              pipe_r,
  input logic [DATA_W-1:0] rdata_r
);

  // R6: output enable inactive at the edge keeps the output unchanged.
  assert_oe_hold_l_R6: assert property (@(posedge clk_l) disable iff (rst_l)
    (!$past(rst_l) && $past(drive_n_l)) |-> rdata_l == $past(rdata_l));

  assert_oe_hold_r_R6: assert property (@(posedge clk_r) disable iff (rst_r)
    (!$past(rst_r) && $past(drive_n_r)) |-> rdata_r == $past(rdata_r));

  // R2 / R7: deselected edge in flow-through mode produces no new data.
  assert_desel_hold_l_R7: assert property (@(posedge clk_l) disable iff (rst_l)
    (!$past(rst_l) && !$past(pipe_l) && !(!$past(gate_n_l) && $past(gate_l)))
    |-> rdata_l == $past(rdata_l));

  // R7: a write edge in flow-through mode produces no new data.
  assert_write_hold_l_R7: assert property (@(posedge clk_l) disable iff (rst_l)
    (!$past(rst_l) && !$past(pipe_l) && !$past(wr_n_l))
    |-> rdata_l == $past(rdata_l));

  // R8: pipelined port deselected two edges back shows nothing new.
  assert_pipe_restart_r_R8: assert property (@(posedge clk_r) disable iff (rst_r)
    (!$past(rst_r) && !$past(rst_r, 2) && $past(pipe_r)
     && !(!$past(gate_n_r, 2) && $past(gate_r, 2)))
    |-> rdata_r == $past(rdata_r));

  // R11: reset edge leaves the output at zero.
  assert_reset_clear_l_R11: assert property (@(posedge clk_l)
    $past(rst_l) && rst_l |-> rdata_l == '0);

endmodule

bind dpram_dual_sync dpram_dual_sync_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_dpram_dual_sync.sv
module test_dpram_dual_sync;
  localparam int AW = 11;
  localparam int DW = 9;

  // 50 MHz: 20 time units of 1 ns per period.
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_l = 1'b1, rst_r = 1'b1;
  logic [AW-1:0] addr_l = '0, addr_r = '0;
  logic [DW-1:0] wdata_l = '0, wdata_r = '0;
  logic          wr_n_l = 1'b1, wr_n_r = 1'b1;
  logic          drive_n_l = 1'b0, drive_n_r = 1'b0;
  logic          gate_n_l = 1'b1, gate_n_r = 1'b1;
  logic          gate_l = 1'b0, gate_r = 1'b0;
  logic          pipe_l = 1'b0, pipe_r = 1'b1;
  logic [DW-1:0] rdata_l, rdata_r;

  int n_cmp = 0;
  int n_bad = 0;

  dpram_dual_sync #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_dual_sync (
    .clk_l(clk), .rst_l(rst_l), .addr_l(addr_l), .wdata_l(wdata_l),
    .wr_n_l(wr_n_l), .drive_n_l(drive_n_l), .gate_n_l(gate_n_l),
    .gate_l(gate_l), .pipe_l(pipe_l), .rdata_l(rdata_l),
    .clk_r(clk), .rst_r(rst_r), .addr_r(addr_r), .wdata_r(wdata_r),
    .wr_n_r(wr_n_r), .drive_n_r(drive_n_r), .gate_n_r(gate_n_r),
    .gate_r(gate_r), .pipe_r(pipe_r), .rdata_r(rdata_r)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_l(input logic wn, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic dn,
                       input logic gn, input logic g);
    wr_n_l = wn; addr_l = a; wdata_l = d; drive_n_l = dn;
    gate_n_l = gn; gate_l = g;
  endtask

  task automatic put_r(input logic wn, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic dn,
                       input logic gn, input logic g);
    wr_n_r = wn; addr_r = a; wdata_r = d; drive_n_r = dn;
    gate_n_r = gn; gate_r = g;
  endtask

  task automatic idle_l(); put_l(1'b1, '0, '0, 1'b0, 1'b1, 1'b0); endtask
  task automatic idle_r(); put_r(1'b1, '0, '0, 1'b0, 1'b1, 1'b0); endtask
  task automatic step(); @(negedge clk); endtask

  task automatic t_reset();
    repeat (3) step();
    rst_l = 1'b0; rst_r = 1'b0;
    step();
    check("R11 reset left", rdata_l, '0);
    check("R11 reset right", rdata_r, '0);
  endtask

  task automatic t_flow();
    put_l(1'b0, 11'd5, 9'h1A5, 1'b0, 1'b0, 1'b1); step();
    check("R7 write edge holds", rdata_l, '0);
    put_l(1'b1, 11'd5, '0, 1'b0, 1'b0, 1'b1); step();
    check("R3 R4 flow read", rdata_l, 9'h1A5);
    idle_l(); step();
    check("R7 idle holds", rdata_l, 9'h1A5);
  endtask

  task automatic t_pipe();
    put_r(1'b1, 11'd5, '0, 1'b0, 1'b0, 1'b1); step();
    check("R5 pipe not yet", rdata_r, '0);
    idle_r(); step();
    check("R5 pipe one edge later", rdata_r, 9'h1A5);
  endtask

  task automatic t_select();
    put_l(1'b0, 11'd7, 9'h055, 1'b0, 1'b0, 1'b1); step();
    put_l(1'b0, 11'd7, 9'h1FF, 1'b0, 1'b1, 1'b1); step();
    put_l(1'b0, 11'd7, 9'h100, 1'b0, 1'b0, 1'b0); step();
    put_l(1'b0, 11'd7, 9'h0AB, 1'b0, 1'b1, 1'b0); step();
    put_l(1'b1, 11'd7, '0, 1'b0, 1'b0, 1'b1); step();
    check("R2 deselected writes ignored", rdata_l, 9'h055);
    put_l(1'b1, 11'd5, '0, 1'b0, 1'b1, 1'b1); step();
    check("R2 deselected read ignored", rdata_l, 9'h055);
  endtask

  task automatic t_oe();
    put_l(1'b1, 11'd5, '0, 1'b1, 1'b0, 1'b1); step();
    check("R6 flow oe off holds", rdata_l, 9'h055);
    idle_l();
    put_r(1'b1, 11'd7, '0, 1'b0, 1'b0, 1'b1); step();
    put_r(1'b1, '0, '0, 1'b1, 1'b1, 1'b0); step();
    check("R6 pipe oe off at output edge", rdata_r, 9'h1A5);
    put_r(1'b1, 11'd7, '0, 1'b1, 1'b0, 1'b1); step();
    idle_r(); step();
    check("R6 pipe oe on at output edge", rdata_r, 9'h055);
  endtask

  task automatic t_restart();
    put_r(1'b0, 11'd20, 9'h0C3, 1'b0, 1'b0, 1'b1); step();
    put_r(1'b0, 11'd21, 9'h13C, 1'b0, 1'b0, 1'b1); step();
    idle_r(); step();
    put_r(1'b1, 11'd20, '0, 1'b0, 1'b0, 1'b1); step();
    check("R8 first edge after reselect holds", rdata_r, 9'h055);
    put_r(1'b1, 11'd21, '0, 1'b0, 1'b0, 1'b1); step();
    check("R8 first read", rdata_r, 9'h0C3);
    idle_r(); step();
    check("R8 second read", rdata_r, 9'h13C);
  endtask

  task automatic t_cross();
    put_l(1'b0, 11'd30, 9'h111, 1'b0, 1'b0, 1'b1); step();
    put_l(1'b0, 11'd30, 9'h0EE, 1'b0, 1'b0, 1'b1);
    put_r(1'b1, 11'd30, '0, 1'b0, 1'b0, 1'b1); step();
    idle_l(); idle_r(); step();
    check("R9 other-port read gets old word", rdata_r, 9'h111);
    put_l(1'b1, 11'd30, '0, 1'b0, 1'b0, 1'b1); step();
    check("R9 R3 new word stored", rdata_l, 9'h0EE);
    idle_l();
  endtask

  task automatic t_dual();
    put_l(1'b0, 11'd40, 9'h1C1, 1'b0, 1'b0, 1'b1);
    put_r(1'b0, 11'd41, 9'h03E, 1'b0, 1'b0, 1'b1); step();
    put_l(1'b1, 11'd41, '0, 1'b0, 1'b0, 1'b1);
    put_r(1'b1, 11'd40, '0, 1'b0, 1'b0, 1'b1); step();
    check("R10 left sees right write", rdata_l, 9'h03E);
    idle_l(); idle_r(); step();
    check("R10 right sees left write", rdata_r, 9'h1C1);
  endtask

  task automatic t_depth();
    put_l(1'b0, 11'h7FF, 9'h1FF, 1'b0, 1'b0, 1'b1); step();
    put_l(1'b0, 11'h000, 9'h000, 1'b0, 1'b0, 1'b1); step();
    put_l(1'b1, 11'h7FF, '0, 1'b0, 1'b0, 1'b1); step();
    check("R1 top word", rdata_l, 9'h1FF);
    put_l(1'b1, 11'h000, '0, 1'b0, 1'b0, 1'b1); step();
    check("R1 word zero distinct", rdata_l, 9'h000);
    idle_l();
  endtask

  task automatic t_mid_reset();
    put_l(1'b1, 11'd5, '0, 1'b0, 1'b0, 1'b1); step();
    check("R11 before reset", rdata_l, 9'h1A5);
    rst_l = 1'b1; step();
    check("R11 reset clears output", rdata_l, '0);
    rst_l = 1'b0; step();
    check("R11 memory kept", rdata_l, 9'h1A5);
    idle_l(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_flow();
    t_pipe();
    t_select();
    t_oe();
    t_restart();
    t_cross();
    t_dual();
    t_depth();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule